// File: doc/BRIEF.md
# Strap-Sampled Clock Power Controller

This block is the digital control section of a multi-output clock generator. While reset is held at power-up it captures configuration straps from pins that later carry clocks. After a fixed number of reference cycles it reports that those pins now drive outputs. Host-bus, PCI, fixed-frequency and reference clocks are all generated elsewhere and arrive as input clocks. The block selects among them and gates them, and it never cuts a pulse short.

Two active-low control inputs, `stop_n` and `slow_n`, pass through a two-stage synchronizer and select one of four power states. In the full-run state every output runs at its normal rate. In the reduced-speed state the host outputs move to the 33 MHz source. In the clock-stop state the auxiliary host output is clamped low, and the regular PCI output follows a strap. In the oscillator-off state every output is low and the oscillator and PLL enables drop. When the block leaves the oscillator-off state, the outputs stay low for a settle interval so that the analog sources can restart.

Top module: `clkpwr_ctrl`

## Requirements
- R1: Strap pins are captured only while `rst` is high. Changes on `strap_pad` after reset release have no effect on any output until the next reset. Bit 3 is the PCI-keep strap, bit 2 is the PCI-synchronous strap and bits 1:0 are the host frequency code.
- R2: `pads_out` is low during reset and goes high on exactly the `PWRUP_CYCLES`-th rising edge of `clk` after reset release. Until then every clock output stays low.
- R3: `fsel` presents the captured host frequency code: 00 = 66.66 MHz, 01 = 60 MHz, 10 = 75 MHz, 11 = 50 MHz.
- R4: With `stop_n`=1 and `slow_n`=1, both host outputs follow `host_fast_clk`, and the PCI, free-running PCI, fixed and reference outputs all run.
- R5: With `stop_n`=1 and `slow_n`=0, both host outputs follow `host_slow_clk`, and all PCI, fixed and reference outputs keep running.
- R6: With `stop_n`=0 and `slow_n`=0, `host_aux_o` is held low. `host_main_o` (fast source), `pcif_o`, `fixed_o` and `ref_o` run. `pci_o` runs if the PCI-keep strap is 1 and is held low if it is 0.
- R7: With `stop_n`=0 and `slow_n`=1, all clock outputs are low and `osc_en` and `pll_en` are 0. In every other state both enables are 1.
- R8: After the block leaves the oscillator-off state, all clock outputs stay low for at least `SETTLE_CYCLES` reference cycles after `osc_en` returns to 1. Then they resume.
- R9: The PCI-synchronous strap picks the PCI source for `pci_o` and `pcif_o`: 1 selects `pci_sync_clk` (half the host rate), 0 selects `pci_async_clk`.
- R10: A change on the control inputs reaches `osc_en`/`pll_en` on the third rising edge of `clk` after the change, and not earlier.
- R11: No clock output produces a high pulse shorter than the shortest high phase of its sources, including at source switches and gate changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; control logic clock and source of `ref_o` |
| rst | input | 1 | Synchronous active-high power-up reset |
| stop_n | input | 1 | Active-low stop control, asynchronous |
| slow_n | input | 1 | Active-low slow control, asynchronous |
| strap_pad | input | 4 | Strap levels on the dual-purpose pins |
| host_fast_clk | input | 1 | Selected-frequency host source |
| host_slow_clk | input | 1 | 33 MHz host source |
| pci_sync_clk | input | 1 | PCI source at half the host rate |
| pci_async_clk | input | 1 | Free 33 MHz PCI source |
| fixed_clk | input | 1 | Fixed-frequency source |
| host_main_o | output | 1 | Host clock group that runs in clock-stop |
| host_aux_o | output | 1 | Host clock group clamped in clock-stop |
| pci_o | output | 1 | Regular PCI clock |
| pcif_o | output | 1 | Free-running PCI clock |
| fixed_o | output | 1 | Fixed-frequency clock |
| ref_o | output | 1 | Reference clock output |
| osc_en | output | 1 | Oscillator enable |
| pll_en | output | 1 | PLL enable |
| fsel | output | 2 | Captured host frequency code |
| pads_out | output | 1 | Dual-purpose pins now drive outputs |

## Verification
A direct move from the reduced-speed state into the clock-stop state does two things in the same control cycle. It swings the host mux from the 33 MHz source back to the fast source, and it closes the auxiliary host gate. The bench makes this move with a single edge on `stop_n` while `slow_n` stays low. A pulse-width monitor on the host output reports any high phase shorter than the fast source's high phase. Edge counts over a fixed window then confirm the new rates of both host outputs.

// File: rtl/clkpwr_pkg.sv
package clkpwr_pkg;

    typedef struct packed {
        logic       pci_keep;
        logic       pci_sync;
        logic [1:0] fsel;
    } strap_t;

    localparam int STRAP_W = $bits(strap_t);

    typedef enum logic [1:0] {
        PS_ON     = 2'd0,
        PS_SLOW   = 2'd1,
        PS_CLKOFF = 2'd2,
        PS_PLLOFF = 2'd3
    } pstate_e;

    localparam int NOUT    = 6;
    localparam int IX_MAIN = 0;
    localparam int IX_AUX  = 1;
    localparam int IX_PCI  = 2;
    localparam int IX_PCIF = 3;
    localparam int IX_FIX  = 4;
    localparam int IX_REF  = 5;

    function automatic pstate_e decode_state(input logic stop_n, input logic slow_n);
        case ({stop_n, slow_n})
            2'b11:   return PS_ON;
            2'b10:   return PS_SLOW;
            2'b00:   return PS_CLKOFF;
            default: return PS_PLLOFF;
        endcase
    endfunction

    function automatic logic [NOUT-1:0] gate_map(input pstate_e s, input logic pci_keep);
        logic [NOUT-1:0] m;
        m = '1;
        case (s)
            PS_CLKOFF: begin
                m[IX_AUX] = 1'b0;
                m[IX_PCI] = pci_keep;
            end
            PS_PLLOFF: m = '0;
            default:   ;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/clkpwr_strap_timer.sv
module clkpwr_strap_timer
    import clkpwr_pkg::*;
#(
    parameter int PWRUP_CYCLES = 143182
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [STRAP_W-1:0] pad_in,
    output strap_t             strap,
    output logic               pads_out
);
    localparam int CW = $clog2(PWRUP_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(PWRUP_CYCLES - 1);

    logic [CW-1:0] cnt;

    // straps are only captured while the power-up reset is asserted
    always_ff @(posedge clk) begin
        if (rst) strap <= strap_t'(pad_in);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            pads_out <= 1'b0;
        end else if (!pads_out) begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST) pads_out <= 1'b1;
        end
    end

    a_r2_rise_at_terminal: assert property (@(posedge clk) disable iff (rst)
        $rose(pads_out) |-> ($past(cnt) == LAST));

    a_r2_outputs_latch: assert property (@(posedge clk) disable iff (rst)
        pads_out |=> pads_out);

endmodule

// File: rtl/clkpwr_mode.sv
module clkpwr_mode
    import clkpwr_pkg::*;
#(
    parameter int SETTLE_CYCLES = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            stop_n,
    input  logic            slow_n,
    input  logic            pads_out,
    input  logic            pci_keep,
    output logic [NOUT-1:0] en,
    output logic            host_slow,
    output logic            osc_en,
    output logic            pll_en
);
    localparam int SW = $clog2(SETTLE_CYCLES + 1);
    localparam logic [SW-1:0] SLOAD = SW'(SETTLE_CYCLES);

    logic [1:0]    stop_sy, slow_sy;
    logic [SW-1:0] settle_cnt;
    logic          settling;
    pstate_e       st;

    always_ff @(posedge clk) begin
        if (rst) begin
            stop_sy <= 2'b11;
            slow_sy <= 2'b11;
        end else begin
            stop_sy <= {stop_sy[0], stop_n};
            slow_sy <= {slow_sy[0], slow_n};
        end
    end

    assign st = decode_state(stop_sy[1], slow_sy[1]);

    always_ff @(posedge clk) begin
        if (rst)                   settle_cnt <= '0;
        else if (st == PS_PLLOFF)  settle_cnt <= SLOAD;
        else if (settling)         settle_cnt <= settle_cnt - 1'b1;
    end

    assign settling = (settle_cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            en        <= '0;
            host_slow <= 1'b0;
            osc_en    <= 1'b1;
            pll_en    <= 1'b1;
        end else begin
            en        <= (pads_out && !settling) ? gate_map(st, pci_keep) : '0;
            host_slow <= (st == PS_SLOW);
            osc_en    <= (st != PS_PLLOFF);
            pll_en    <= (st != PS_PLLOFF);
        end
    end

    a_r7_plloff_all_quiet: assert property (@(posedge clk) disable iff (rst)
        (st == PS_PLLOFF) |=> (!osc_en && !pll_en && en == '0));

    a_r8_settle_holds_low: assert property (@(posedge clk) disable iff (rst)
        settling |=> (en == '0));

    a_r6_aux_clamped: assert property (@(posedge clk) disable iff (rst)
        (st == PS_CLKOFF) |=> !en[IX_AUX]);

    a_r2_quiet_before_out: assert property (@(posedge clk) disable iff (rst)
        !pads_out |=> (en == '0));

endmodule

// File: rtl/clkpwr_cgmux.sv
module clkpwr_cgmux (
    input  logic rst,
    input  logic clk_a,
    input  logic clk_b,
    input  logic sel_b,
    input  logic en,
    output logic clk_o
);
    logic a_s, a_on, b_s, b_on;
    logic a_req, b_req;

    // each path may open only once the other path is fully closed
    assign a_req = en && !sel_b && !b_s && !b_on;
    assign b_req = en &&  sel_b && !a_s && !a_on;

    always_ff @(posedge clk_a) begin
        if (rst) a_s <= 1'b0;
        else     a_s <= a_req;
    end

    // the enable changes on the falling edge, so only while the source is low
    always_ff @(negedge clk_a) begin
        if (rst) a_on <= 1'b0;
        else     a_on <= a_s;
    end

    always_ff @(posedge clk_b) begin
        if (rst) b_s <= 1'b0;
        else     b_s <= b_req;
    end

    always_ff @(negedge clk_b) begin
        if (rst) b_on <= 1'b0;
        else     b_on <= b_s;
    end

    assign clk_o = (clk_a && a_on) || (clk_b && b_on);

endmodule

// File: rtl/clkpwr_ctrl.sv
module clkpwr_ctrl
    import clkpwr_pkg::*;
#(
    parameter int PWRUP_CYCLES  = 143182,
    parameter int SETTLE_CYCLES = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               stop_n,
    input  logic               slow_n,
    input  logic [STRAP_W-1:0] strap_pad,
    input  logic               host_fast_clk,
    input  logic               host_slow_clk,
    input  logic               pci_sync_clk,
    input  logic               pci_async_clk,
    input  logic               fixed_clk,
    output logic               host_main_o,
    output logic               host_aux_o,
    output logic               pci_o,
    output logic               pcif_o,
    output logic               fixed_o,
    output logic               ref_o,
    output logic               osc_en,
    output logic               pll_en,
    output logic [1:0]         fsel,
    output logic               pads_out
);
    strap_t          strap;
    logic [NOUT-1:0] en;
    logic            host_slow;
    logic [NOUT-1:0] src_a, src_b, sel_b, clk_out;

    clkpwr_strap_timer #(.PWRUP_CYCLES(PWRUP_CYCLES)) u_strap (
        .clk      (clk),
        .rst      (rst),
        .pad_in   (strap_pad),
        .strap    (strap),
        .pads_out (pads_out)
    );

    clkpwr_mode #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_mode (
        .clk       (clk),
        .rst       (rst),
        .stop_n    (stop_n),
        .slow_n    (slow_n),
        .pads_out  (pads_out),
        .pci_keep  (strap.pci_keep),
        .en        (en),
        .host_slow (host_slow),
        .osc_en    (osc_en),
        .pll_en    (pll_en)
    );

    // index order: REF, FIX, PCIF, PCI, AUX, MAIN
    assign src_a = {clk, fixed_clk, pci_async_clk, pci_async_clk, host_fast_clk, host_fast_clk};
    assign src_b = {clk, fixed_clk, pci_sync_clk,  pci_sync_clk,  host_slow_clk, host_slow_clk};
    assign sel_b = {1'b0, 1'b0, strap.pci_sync, strap.pci_sync, host_slow, host_slow};

    for (genvar i = 0; i < NOUT; i++) begin : g_out
        clkpwr_cgmux u_mux (
            .rst   (rst),
            .clk_a (src_a[i]),
            .clk_b (src_b[i]),
            .sel_b (sel_b[i]),
            .en    (en[i]),
            .clk_o (clk_out[i])
        );
    end

    assign host_main_o = clk_out[IX_MAIN];
    assign host_aux_o  = clk_out[IX_AUX];
    assign pci_o       = clk_out[IX_PCI];
    assign pcif_o      = clk_out[IX_PCIF];
    assign fixed_o     = clk_out[IX_FIX];
    assign ref_o       = clk_out[IX_REF];
    assign fsel        = strap.fsel;

endmodule

// File: tb/clkpwr_ctrl_bench.sv
`timescale 1ns/1ps
module clkpwr_ctrl_bench;
    localparam int PWRUP  = 40;
    localparam int SETTLE = 16;

    logic clk = 0, hf = 0, hs = 0, ps = 0, pa = 0, fx = 0;
    logic rst, stop_n, slow_n;
    logic [3:0] strap_pad;
    logic host_main_o, host_aux_o, pci_o, pcif_o, fixed_o, ref_o;
    logic osc_en, pll_en, pads_out;
    logic [1:0] fsel;

    always #2.5 clk = ~clk;
    always #4   hf  = ~hf;
    always #15  hs  = ~hs;
    always #8   ps  = ~ps;
    always #14  pa  = ~pa;
    always #10  fx  = ~fx;

    clkpwr_ctrl #(.PWRUP_CYCLES(PWRUP), .SETTLE_CYCLES(SETTLE)) u_clkpwr_ctrl (
        .clk(clk), .rst(rst), .stop_n(stop_n), .slow_n(slow_n), .strap_pad(strap_pad),
        .host_fast_clk(hf), .host_slow_clk(hs), .pci_sync_clk(ps), .pci_async_clk(pa),
        .fixed_clk(fx), .host_main_o(host_main_o), .host_aux_o(host_aux_o), .pci_o(pci_o),
        .pcif_o(pcif_o), .fixed_o(fixed_o), .ref_o(ref_o), .osc_en(osc_en), .pll_en(pll_en),
        .fsel(fsel), .pads_out(pads_out));

    int n_chk = 0, n_fail = 0;
    int c_main = 0, c_aux = 0, c_pci = 0, c_pcif = 0, c_fix = 0, c_ref = 0;
    int runts = 0;
    bit finished = 0;
    bit keep_q, sync_q;
    realtime t_rise = 0.0;

    always @(posedge host_main_o) c_main++;
    always @(posedge host_aux_o)  c_aux++;
    always @(posedge pci_o)       c_pci++;
    always @(posedge pcif_o)      c_pcif++;
    always @(posedge fixed_o)     c_fix++;
    always @(posedge ref_o)       c_ref++;

    always @(posedge host_main_o) t_rise = $realtime;
    always @(negedge host_main_o) if ($realtime - t_rise < 3.9) runts++;

    // kinds: 0 stopped, 1 host fast, 2 host slow, 3 pci sync, 4 pci async, 5 fixed, 6 ref
    task automatic range_of(input int kind, output int lo, output int hi);
        case (kind)
            0: begin lo = 0;  hi = 0;  end
            1: begin lo = 40; hi = 60; end
            2: begin lo = 10; hi = 16; end
            3: begin lo = 20; hi = 30; end
            4: begin lo = 11; hi = 17; end
            5: begin lo = 17; hi = 23; end
            default: begin lo = 75; hi = 85; end
        endcase
    endtask

    function automatic int exp_kind(input int idx, input int st, input bit keep, input bit sy);
        int pk;
        pk = sy ? 3 : 4;
        if (st == 3) return 0;
        case (idx)
            0: return (st == 1) ? 2 : 1;
            1: return (st == 0) ? 1 : (st == 1) ? 2 : 0;
            2: return (st == 2 && !keep) ? 0 : pk;
            3: return pk;
            4: return 5;
            default: return 6;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int ex);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, ex);
        end
    endtask

    task automatic chk_rate(input string req, input string what, input int act, input int kind);
        int lo, hi;
        range_of(kind, lo, hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
        end
    endtask

    task automatic clear_counts();
        c_main = 0; c_aux = 0; c_pci = 0; c_pcif = 0; c_fix = 0; c_ref = 0;
    endtask

    function automatic string tag_of(input int st);
        case (st)
            0: return "R4";
            1: return "R5";
            2: return "R6";
            default: return "R7";
        endcase
    endfunction

    // st: 0 full-run, 1 reduced-speed, 2 clock-stop, 3 oscillator-off
    task automatic run_state(input int st);
        string t;
        t = tag_of(st);
        @(negedge clk);
        stop_n = (st == 0 || st == 1);
        slow_n = (st == 0 || st == 3);
        repeat (40) @(negedge clk);
        clear_counts();
        repeat (80) @(negedge clk);
        chk_rate(t, "host_main", c_main, exp_kind(0, st, keep_q, sync_q));
        chk_rate(t, "host_aux",  c_aux,  exp_kind(1, st, keep_q, sync_q));
        chk_rate(sync_q ? "R9" : t, "pci",  c_pci,  exp_kind(2, st, keep_q, sync_q));
        chk_rate(sync_q ? "R9" : t, "pcif", c_pcif, exp_kind(3, st, keep_q, sync_q));
        chk_rate(t, "fixed", c_fix, exp_kind(4, st, keep_q, sync_q));
        chk_rate(t, "ref",   c_ref, exp_kind(5, st, keep_q, sync_q));
        chk({osc_en, pll_en} == ((st == 3) ? 2'b00 : 2'b11), "R7", "osc/pll enables",
            {osc_en, pll_en}, (st == 3) ? 0 : 3);
        chk(runts == 0, "R11", "host pulse width", runts, 0);
    endtask

    task automatic power_up(input logic [3:0] s, input logic [3:0] later);
        @(negedge clk);
        rst = 1; stop_n = 1; slow_n = 1; strap_pad = s;
        keep_q = s[3]; sync_q = s[2];
        repeat (4) @(negedge clk);
        chk(pads_out == 1'b0, "R2", "pads_out in reset", pads_out, 0);
        chk(osc_en && pll_en, "R7", "enables in reset", {osc_en, pll_en}, 3);
        rst = 0;
        strap_pad = later;                        // R1: must be ignored
        clear_counts();
        repeat (PWRUP - 1) @(posedge clk);
        @(negedge clk);
        chk(pads_out == 1'b0, "R2", "pads_out one edge early", pads_out, 0);
        chk(c_main + c_aux + c_pci + c_pcif + c_fix + c_ref == 0, "R2", "edges before outputs",
            c_main + c_aux + c_pci + c_pcif + c_fix + c_ref, 0);
        @(posedge clk);
        @(negedge clk);
        chk(pads_out == 1'b1, "R2", "pads_out at terminal edge", pads_out, 1);
        chk(fsel == s[1:0], "R3", "fsel code", fsel, s[1:0]);
    endtask

    initial begin
        void'($urandom(32'd5150));
        rst = 1; stop_n = 1; slow_n = 1; strap_pad = 4'b0000;

        // first power-up: keep=0, async PCI, code 01; pins later driven to 1110
        power_up(4'b0001, 4'b1110);
        run_state(0);
        chk(fsel == 2'b01, "R1", "fsel after pad change", fsel, 1);
        run_state(1);
        run_state(2);                             // direct reduced-speed -> clock-stop
        run_state(3);

        // R10 and R8: leave oscillator-off
        @(negedge clk);
        stop_n = 1; slow_n = 1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(osc_en == 1'b0, "R10", "osc_en after two edges", osc_en, 0);
        @(posedge clk);
        @(negedge clk);
        chk(osc_en == 1'b1, "R10", "osc_en after three edges", osc_en, 1);
        clear_counts();
        repeat (SETTLE - 1) @(negedge clk);
        chk(c_main + c_aux + c_pci + c_pcif + c_fix + c_ref == 0, "R8", "edges while settling",
            c_main + c_aux + c_pci + c_pcif + c_fix + c_ref, 0);
        run_state(0);                             // R8: resumes afterwards

        for (int i = 0; i < 10; i++) run_state(int'($urandom_range(0, 3)));

        // second power-up: keep=1, sync PCI, code 10; pins later driven to 0001
        power_up(4'b1110, 4'b0001);
        run_state(2);
        chk(fsel == 2'b10, "R1", "fsel after pad change", fsel, 2);
        run_state(1);
        run_state(3);
        for (int i = 0; i < 10; i++) run_state(int'($urandom_range(0, 3)));

        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(500_000);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule